// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a small data cache that sits between a processor port that makes word-sized reads and writes and a simple backing-memory port. It keeps a few lines of consecutive words. Each line is located by the index bits of the byte address and is identified by a stored tag. An access hits when the indexed line is valid and its tag matches the tag bits of the address. A hit is served from local storage. A miss goes to memory.

Two parameters choose the write behaviour, and any combination of the two is legal. The first selects write-back, in which a dirty line is written out only when it is replaced, or write-through, in which every write also goes to memory. The second selects whether a write miss fetches the line first or goes straight to memory. Line fills and dirty evictions move whole lines as bursts of consecutive words, starting at word 0. The processor sees a single-cycle `cpu_ready` pulse when an access completes, and sees `cpu_stall` high while an access is in progress.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_stall`, `cpu_ready` and `mem_req` are low, and the first access to any index misses and fetches its line from memory.
- R2: A byte address is split, from the top down, into tag (bits 15:6), line index (bits 5:4), word within the line (bits 3:2) and byte (bits 1:0). The byte bits have no effect on which word is read or written.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit makes no memory access, and its `cpu_ready` pulse comes two cycles after the request is accepted.
- R4: A read miss fetches the line as four memory reads of the word addresses 0, 1, 2 and 3 of that line, in that order, and then returns the requested word on `cpu_rdata`.
- R5: A write hit replaces only the addressed word of the line. The other words of the line keep their values.
- R6: In write-back mode a write hit makes no memory access and marks the line dirty. A dirty line that is replaced is first written out as four memory writes, word 0 first, to its old address. All of these writes finish before the first read of the new line. A clean line that is replaced causes no memory write.
- R7: In write-through mode every write makes exactly one single-word memory write of the written data to the written address. A write hit also updates the cached copy.
- R8: On a write miss with allocation the line is fetched and the word is then written into it. Without allocation the write goes to memory only, and the cache contents are unchanged.
- R9: A request is accepted only while `cpu_stall` is low. `cpu_stall` is high from the cycle after acceptance until the cycle in which `cpu_ready` pulses for exactly one cycle. A request raised while stalled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, sampled while not stalled |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_stall | output | 1 | High while an accepted access is in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a memory write beat |
| mem_addr | output | 16 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts or completes the current beat |
| mem_rdata | input | 32 | Memory read data for an acknowledged read beat |

## Verification
A completion and a new acceptance can fall in the same cycle. The bench provokes this by raising a read of the same word in the very cycle where `cpu_ready` reports a write hit. The read must be accepted on the next edge, finish two cycles later, and return the freshly written word. A dirty eviction and the line fill that follows it form a second overlap point. The bench judges these from the order of the memory beat log. All eviction writes must come before any fill read, and the written-out data must include the earlier write hit. Two instances run side by side, one in write-back with allocation and one in write-through without allocation. The expected memory traffic and read data are derived separately for each instance.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int  LINES      = 4,
  parameter int  TAG_W      = 10,
  parameter bit  WRITE_BACK = 1'b1,
  localparam int IDX_W      = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] line_idx,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             fill_done,
  input  logic             dirty_set,
  output logic             hit,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag
);
  logic [LINES-1:0] valid_w;
  logic [LINES-1:0] dirty_w;
  logic [TAG_W-1:0] tag_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    wire              sel = (line_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else if (sel && fill_done) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel && fill_done) t_q <= line_tag;
    end

    if (WRITE_BACK) begin : g_dirty
      logic d_q;
      always_ff @(posedge clk) begin
        if (rst) d_q <= 1'b0;
        else if (sel && fill_done) d_q <= 1'b0;
        else if (sel && dirty_set) d_q <= 1'b1;
      end
      assign dirty_w[g] = d_q;
    end else begin : g_clean
      assign dirty_w[g] = 1'b0;
    end

    assign valid_w[g] = v_q;
    assign tag_w[g]   = t_q;
  end

  assign vic_valid = valid_w[line_idx];
  assign vic_dirty = dirty_w[line_idx];
  assign vic_tag   = tag_w[line_idx];
  assign hit       = vic_valid && (vic_tag == line_tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int  LINES  = 4,
  parameter int  WPL    = 4,
  parameter int  WORD_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WOFF_W = $clog2(WPL),
  localparam int DEPTH  = LINES * WPL
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic              wr_en,
  input  logic [WOFF_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WOFF_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[{line_idx, wr_word}] <= wr_data;
  end

  assign rd_data = store_q[{line_idx, rd_word}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORD_W      = 32,
  parameter int IDX_W       = 2,
  parameter int WOFF_W      = 2,
  parameter int BOFF_W      = 2,
  parameter int TAG_W       = 10,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [ADDR_W-1:BOFF_W]   cpu_waddr,
  input  logic [WORD_W-1:0]        cpu_wdata,
  output logic                     cpu_ready,
  output logic [WORD_W-1:0]        cpu_rdata,
  output logic                     cpu_stall,
  input  logic                     hit,
  input  logic                     vic_valid,
  input  logic                     vic_dirty,
  input  logic [TAG_W-1:0]         vic_tag,
  output logic [IDX_W-1:0]         line_idx,
  output logic [TAG_W-1:0]         line_tag,
  output logic                     fill_done,
  output logic                     dirty_set,
  output logic                     ds_we,
  output logic [WOFF_W-1:0]        ds_wword,
  output logic [WORD_W-1:0]        ds_wdata,
  output logic [WOFF_W-1:0]        ds_rword,
  input  logic [WORD_W-1:0]        ds_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [WORD_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [WORD_W-1:0]        mem_rdata
);
  dmc_state_e              state_q;
  logic [ADDR_W-1:BOFF_W]  addr_q;
  logic                    we_q;
  logic [WORD_W-1:0]       wdata_q;
  logic [WOFF_W-1:0]       beat_q;
  logic [WOFF_W-1:0]       word_sel;
  logic                    last_beat;
  logic                    wr_hit;

  assign line_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign line_idx  = addr_q[BOFF_W+WOFF_W +: IDX_W];
  assign word_sel  = addr_q[BOFF_W +: WOFF_W];
  assign last_beat = (beat_q == {WOFF_W{1'b1}});
  assign wr_hit    = (state_q == ST_LOOKUP) && hit && we_q;
  assign cpu_stall = (state_q != ST_IDLE);

  assign fill_done = (state_q == ST_FILL) && mem_ack && last_beat;
  assign ds_we     = wr_hit || ((state_q == ST_FILL) && mem_ack);
  assign ds_wword  = (state_q == ST_FILL) ? beat_q : word_sel;
  assign ds_wdata  = (state_q == ST_FILL) ? mem_rdata : wdata_q;
  assign ds_rword  = (state_q == ST_EVICT) ? beat_q : word_sel;

  if (WRITE_BACK) begin : g_wb
    assign dirty_set = wr_hit;
  end else begin : g_wt
    assign dirty_set = 1'b0;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = wdata_q;
    unique case (state_q)
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vic_tag, line_idx, beat_q, {BOFF_W{1'b0}}};
        mem_wdata = ds_rdata;
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {line_tag, line_idx, beat_q, {BOFF_W{1'b0}}};
      end
      ST_WTHRU: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {addr_q, {BOFF_W{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      beat_q    <= '0;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            addr_q  <= cpu_waddr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (hit) begin
            if (!we_q) begin
              cpu_rdata <= ds_rdata;
              cpu_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (WRITE_BACK) begin
              cpu_ready <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_WTHRU;
            end
          end else if (we_q && !WRITE_ALLOC) begin
            state_q <= ST_WTHRU;
          end else if (WRITE_BACK && vic_valid && vic_dirty) begin
            state_q <= ST_EVICT;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_EVICT: begin
          if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_LOOKUP;
          end
        end
        ST_WTHRU: begin
          if (mem_ack) begin
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int  ADDR_W      = 16,
  parameter int  WORD_W      = 32,
  parameter int  LINES       = 4,
  parameter int  WPL         = 4,
  parameter bit  WRITE_BACK  = 1'b1,
  parameter bit  WRITE_ALLOC = 1'b1,
  localparam int BOFF_W      = $clog2(WORD_W / 8),
  localparam int WOFF_W      = $clog2(WPL),
  localparam int IDX_W       = $clog2(LINES),
  localparam int TAG_W       = ADDR_W - IDX_W - WOFF_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              hit, vic_valid, vic_dirty, fill_done, dirty_set;
  logic [TAG_W-1:0]  vic_tag, line_tag;
  logic [IDX_W-1:0]  line_idx;
  logic              ds_we;
  logic [WOFF_W-1:0] ds_wword, ds_rword;
  logic [WORD_W-1:0] ds_wdata, ds_rdata;
  logic              byte_bits_unused;

  assign byte_bits_unused = ^cpu_addr[BOFF_W-1:0];

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W),
    .BOFF_W(BOFF_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK),
    .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_waddr(cpu_addr[ADDR_W-1:BOFF_W]), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .hit(hit), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .line_idx(line_idx), .line_tag(line_tag),
    .fill_done(fill_done), .dirty_set(dirty_set),
    .ds_we(ds_we), .ds_wword(ds_wword), .ds_wdata(ds_wdata),
    .ds_rword(ds_rword), .ds_rdata(ds_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  dmc_tag_store #(
    .LINES(LINES), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
  ) u_tags (
    .clk(clk), .rst(rst),
    .line_idx(line_idx), .line_tag(line_tag),
    .fill_done(fill_done), .dirty_set(dirty_set),
    .hit(hit), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag)
  );

  dmc_data_store #(
    .LINES(LINES), .WPL(WPL), .WORD_W(WORD_W)
  ) u_data (
    .clk(clk), .line_idx(line_idx),
    .wr_en(ds_we), .wr_word(ds_wword), .wr_data(ds_wdata),
    .rd_word(ds_rword), .rd_data(ds_rdata)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int WOFF_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [WOFF_W-1:0] mem_word
);
  // R1: leaving reset puts the controller in its idle state
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_stall && !mem_req));

  // R4: fill reads advance one word per acknowledged beat
  a_r4_fill_sequence: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we && (mem_word != {WOFF_W{1'b1}}))
    |=> (mem_req && !mem_we && (mem_word == $past(mem_word) + WOFF_W'(1))));

  // R9: an accepted request raises the stall
  a_r9_stall_on_accept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |=> cpu_stall);

  // R9: ready lasts a single cycle
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R9: ready and stall never overlap
  a_r9_ready_not_stalled: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !cpu_stall);

  // R3: memory traffic only inside a stalled access
  a_r3_mem_inside_access: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_stall);
endmodule

bind dm_cache dmc_checker #(.WOFF_W(WOFF_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_word(mem_addr[BOFF_W +: WOFF_W])
);

// File: tb/dm_cache_test.sv
module dm_cache_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        req_a = 1'b0, req_b = 1'b0;

  logic        rdy_a, stall_a, mreq_a, mwe_a, mack_a;
  logic [31:0] rdata_a, mwdata_a, mrdata_a;
  logic [15:0] maddr_a;
  logic        rdy_b, stall_b, mreq_b, mwe_b, mack_b;
  logic [31:0] rdata_b, mwdata_b, mrdata_b;
  logic [15:0] maddr_b;

  logic [31:0] mem_a [256];
  logic [31:0] mem_b [256];
  logic [31:0] gold  [256];
  logic [15:0] log_addr_a [128];
  logic        log_we_a   [128];
  int n_a = 0, rdc_a = 0, wrc_a = 0;
  int n_b = 0, rdc_b = 0, wrc_b = 0;
  int checks = 0, fails = 0, cyc = 0;

  dm_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) uut (
    .clk(clk), .rst(rst), .cpu_req(req_a), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(rdy_a), .cpu_rdata(rdata_a), .cpu_stall(stall_a),
    .mem_req(mreq_a), .mem_we(mwe_a), .mem_addr(maddr_a), .mem_wdata(mwdata_a),
    .mem_ack(mack_a), .mem_rdata(mrdata_a));

  dm_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) uut_wt (
    .clk(clk), .rst(rst), .cpu_req(req_b), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(rdy_b), .cpu_rdata(rdata_b), .cpu_stall(stall_b),
    .mem_req(mreq_b), .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwdata_b),
    .mem_ack(mack_b), .mem_rdata(mrdata_b));

  function automatic logic [31:0] init_val(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  function automatic logic [15:0] mk(input int tag, input int idx, input int wd, input int by);
    return {6'b0, 4'(tag), 2'(idx), 2'(wd), 2'(by)};
  endfunction

  assign mack_a   = mreq_a;
  assign mrdata_a = mem_a[maddr_a[9:2]];
  assign mack_b   = mreq_b;
  assign mrdata_b = mem_b[maddr_b[9:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem_a[i] <= init_val(i);
    end else if (mreq_a) begin
      if (n_a < 128) begin
        log_addr_a[n_a] <= maddr_a;
        log_we_a[n_a]   <= mwe_a;
      end
      n_a <= n_a + 1;
      if (mwe_a) begin
        mem_a[maddr_a[9:2]] <= mwdata_a;
        wrc_a <= wrc_a + 1;
      end else rdc_a <= rdc_a + 1;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem_b[i] <= init_val(i);
    end else if (mreq_b) begin
      n_b <= n_b + 1;
      if (mwe_b) begin
        mem_b[maddr_b[9:2]] <= mwdata_b;
        wrc_b <= wrc_b + 1;
      end else rdc_b <= rdc_b + 1;
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit ua, input bit ub, input bit we, input logic [15:0] addr,
                        input logic [31:0] wd, output logic [31:0] ra, output logic [31:0] rb,
                        output int la, output int lb);
    bit da, db;
    int n;
    ra = '0; rb = '0; la = 0; lb = 0;
    @(negedge clk);
    cpu_we = we; cpu_addr = addr; cpu_wdata = wd; req_a = ua; req_b = ub;
    da = !ua; db = !ub;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    n = 1;
    while (!(da && db) && n < 500) begin
      if (!da && rdy_a) begin da = 1'b1; ra = rdata_a; la = n; end
      if (!db && rdy_b) begin db = 1'b1; rb = rdata_b; lb = n; end
      if (!(da && db)) begin @(negedge clk); n++; end
    end
    if (we) gold[addr[9:2]] = wd;
  endtask

  // R1: reset state and first access misses
  task automatic t_reset;
    @(negedge clk);
    chk("R1 stall_a", 32'(stall_a), 0);
    chk("R1 ready_a", 32'(rdy_a), 0);
    chk("R1 memreq_a", 32'(mreq_a), 0);
    chk("R1 stall_b", 32'(stall_b), 0);
    chk("R1 ready_b", 32'(rdy_b), 0);
    chk("R1 memreq_b", 32'(mreq_b), 0);
  endtask

  // R4: read miss burst order and returned word
  task automatic t_read_miss;
    logic [31:0] ra, rb; int la, lb; int s, r0b;
    s = n_a; r0b = rdc_b;
    access(1, 1, 0, mk(1, 2, 1, 0), 0, ra, rb, la, lb);
    chk("R4 rdata_a", ra, gold[mk(1, 2, 1, 0) >> 2]);
    chk("R4 rdata_b", rb, gold[mk(1, 2, 1, 0) >> 2]);
    chk("R1 first access fills a", 32'(n_a - s), 4);
    chk("R1 first access fills b", 32'(rdc_b - r0b), 4);
    for (int k = 0; k < 4; k++) begin
      chk("R4 fill address order", 32'(log_addr_a[s + k]), 32'(mk(1, 2, k, 0)));
      chk("R4 fill is read", 32'(log_we_a[s + k]), 0);
    end
  endtask

  // R3 R2: read hit with byte bits set
  task automatic t_read_hit;
    logic [31:0] ra, rb; int la, lb; int s, sb;
    s = n_a; sb = n_b;
    access(1, 1, 0, mk(1, 2, 3, 3), 0, ra, rb, la, lb);
    chk("R2 byte bits ignored a", ra, gold[mk(1, 2, 3, 0) >> 2]);
    chk("R2 byte bits ignored b", rb, gold[mk(1, 2, 3, 0) >> 2]);
    chk("R3 hit latency a", 32'(la), 2);
    chk("R3 hit latency b", 32'(lb), 2);
    chk("R3 no memory traffic", 32'(n_a - s + n_b - sb), 0);
  endtask

  // R5 R6 R7: write hit
  task automatic t_write_hit;
    logic [31:0] ra, rb; int la, lb; int s, wb0;
    s = n_a; wb0 = wrc_b;
    access(1, 1, 1, mk(1, 2, 2, 0), 32'hD1D1_0001, ra, rb, la, lb);
    chk("R6 write-back hit no memory", 32'(n_a - s), 0);
    chk("R7 write-through one beat", 32'(wrc_b - wb0), 1);
    chk("R7 write-through data", mem_b[mk(1, 2, 2, 0) >> 2], 32'hD1D1_0001);
    s = n_a;
    access(1, 1, 0, mk(1, 2, 2, 0), 0, ra, rb, la, lb);
    chk("R5 written word a", ra, 32'hD1D1_0001);
    chk("R7 cache updated b", rb, 32'hD1D1_0001);
    access(1, 1, 0, mk(1, 2, 1, 0), 0, ra, rb, la, lb);
    chk("R5 neighbour kept a", ra, gold[mk(1, 2, 1, 0) >> 2]);
    chk("R5 neighbour kept b", rb, gold[mk(1, 2, 1, 0) >> 2]);
    chk("R3 hits stay local", 32'(n_a - s), 0);
  endtask

  // R6: dirty eviction before fill, then clean eviction
  task automatic t_evict;
    logic [31:0] ra, rb; int la, lb; int s, wa0, wb0, ra0;
    s = n_a; wb0 = wrc_b;
    access(1, 1, 0, mk(3, 2, 0, 0), 0, ra, rb, la, lb);
    chk("R6 rdata after evict a", ra, gold[mk(3, 2, 0, 0) >> 2]);
    chk("R6 rdata b", rb, gold[mk(3, 2, 0, 0) >> 2]);
    chk("R6 total beats a", 32'(n_a - s), 8);
    for (int k = 0; k < 4; k++) begin
      chk("R6 evict first", 32'(log_we_a[s + k]), 1);
      chk("R6 evict address", 32'(log_addr_a[s + k]), 32'(mk(1, 2, k, 0)));
      chk("R6 fill after evict", 32'(log_we_a[s + 4 + k]), 0);
    end
    chk("R6 dirty data written out", mem_a[mk(1, 2, 2, 0) >> 2], 32'hD1D1_0001);
    chk("R7 no eviction in write-through", 32'(wrc_b - wb0), 0);
    wa0 = wrc_a; ra0 = rdc_a;
    access(1, 1, 0, mk(5, 2, 0, 0), 0, ra, rb, la, lb);
    chk("R6 clean victim no write", 32'(wrc_a - wa0), 0);
    chk("R6 clean victim fill", 32'(rdc_a - ra0), 4);
    chk("R6 rdata clean", ra, gold[mk(5, 2, 0, 0) >> 2]);
  endtask

  // R8: write miss with and without allocation
  task automatic t_write_miss;
    logic [31:0] ra, rb; int la, lb; int ra0, wa0, rb0, wb0;
    ra0 = rdc_a; wa0 = wrc_a; rb0 = rdc_b; wb0 = wrc_b;
    access(1, 1, 1, mk(2, 1, 3, 0), 32'hD2D2_0002, ra, rb, la, lb);
    chk("R8 allocate fills a", 32'(rdc_a - ra0), 4);
    chk("R8 allocate no write a", 32'(wrc_a - wa0), 0);
    chk("R8 no-allocate memory only b", 32'(wrc_b - wb0), 1);
    chk("R8 no-allocate no fill b", 32'(rdc_b - rb0), 0);
    ra0 = rdc_a; rb0 = rdc_b;
    access(1, 1, 0, mk(2, 1, 3, 0), 0, ra, rb, la, lb);
    chk("R8 allocated word a", ra, 32'hD2D2_0002);
    chk("R8 allocated line hits a", 32'(rdc_a - ra0), 0);
    chk("R8 cache unchanged b misses", 32'(rdc_b - rb0), 4);
    chk("R8 memory holds write b", rb, 32'hD2D2_0002);
    access(1, 0, 0, mk(2, 1, 0, 0), 0, ra, rb, la, lb);
    chk("R8 rest of line fetched a", ra, gold[mk(2, 1, 0, 0) >> 2]);
  endtask

  // R9: stall, ready pulse, ignored request
  task automatic t_stall;
    logic [31:0] ra, rb; int la, lb; int wa0, wb0, n;
    wa0 = wrc_a; wb0 = wrc_b;
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = mk(4, 0, 0, 0); req_a = 1'b1; req_b = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0;
    chk("R9 stall after accept a", 32'(stall_a), 1);
    chk("R9 stall after accept b", 32'(stall_b), 1);
    @(negedge clk);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = mk(6, 3, 0, 0); cpu_wdata = 32'hD3D3_0003;
    req_a = 1'b1; req_b = 1'b1;
    @(negedge clk);
    req_a = 1'b0; req_b = 1'b0; cpu_we = 1'b0; cpu_addr = mk(4, 0, 0, 0);
    n = 0;
    while (!rdy_a && n < 500) begin @(negedge clk); n++; end
    chk("R9 ready with stall low a", 32'(stall_a), 0);
    chk("R4 rdata stalled read a", rdata_a, gold[mk(4, 0, 0, 0) >> 2]);
    chk("R9 same completion b", 32'(rdy_b), 1);
    @(negedge clk);
    chk("R9 ready one cycle a", 32'(rdy_a), 0);
    chk("R9 ready one cycle b", 32'(rdy_b), 0);
    chk("R9 ignored write no memory a", 32'(wrc_a - wa0), 0);
    chk("R9 ignored write no memory b", 32'(wrc_b - wb0), 0);
    access(1, 1, 0, mk(6, 3, 0, 0), 0, ra, rb, la, lb);
    chk("R9 ignored write invisible a", ra, gold[mk(6, 3, 0, 0) >> 2]);
    chk("R9 ignored write invisible b", rb, gold[mk(6, 3, 0, 0) >> 2]);
  endtask

  // R5 R9: request in the very cycle of the previous completion
  task automatic t_back_to_back;
    int n;
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = mk(5, 2, 1, 0); cpu_wdata = 32'hD4D4_0004; req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0;
    n = 0;
    while (!rdy_a && n < 500) begin @(negedge clk); n++; end
    gold[mk(5, 2, 1, 0) >> 2] = 32'hD4D4_0004;
    cpu_we = 1'b0; req_a = 1'b1;
    @(negedge clk);
    req_a = 1'b0;
    n = 1;
    while (!rdy_a && n < 500) begin @(negedge clk); n++; end
    chk("R9 back-to-back accepted at once", 32'(n), 2);
    chk("R5 back-to-back read data", rdata_a, 32'hD4D4_0004);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) gold[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_evict();
    t_write_miss();
    t_stall();
    t_back_to_back();
    repeat (2) @(negedge clk);
    report();
  end
endmodule